// File: doc/BRIEF.md
# Paged 24-bit Address Generator

This block forms every memory address the core issues into a unified space of 16M words. Data fetches come from one of two data address generators. Each generator places its own 8-bit page register above a 16-bit index that arrives with the request. The page register of the second generator is also presented on its own output, because the external data path uses it as its page.

Program-flow targets come from one of three modes, chosen per request. A relative branch adds a signed offset to the 24-bit program counter. A direct branch takes a full 24-bit immediate. An indirect branch joins a dedicated jump-page register (upper 8 bits) with a 16-bit data address register (lower 16 bits). The block holds the program counter: it advances on a step pulse and loads the target of any accepted branch. Page registers change only when software writes them.

Each result comes out registered, one cycle after its request, with a valid flag. Instruction decode, post-modify arithmetic on the index and the memory itself belong to other blocks.

Top module: `paged_addr_gen`

## Requirements
- R1: After reset all three page registers read 0, `pc` is 0xFF0000, and `dvalid` and `br_valid` are low.
- R2: A data request with `dreq` high sets `dvalid` high in the next cycle. `daddr` is then {page of the generator picked by `dgen_sel` (0 or 1), `dindex`}. In any cycle after a cycle without a request, `dvalid` is low and `daddr` is 0.
- R3: A page write (`pg_wr_en` high, `pg_wr_sel` 0 = generator 0, 1 = generator 1, 2 = jump page) takes effect from the next cycle. A request in the same cycle as the write uses the old page value.
- R4: `ext_page` always shows the page register of generator 1.
- R5: Mode 0 (relative) targets `pc` plus `br_offset` sign-extended from 16 bits, taken modulo 2^24, so targets wrap past either end of the space.
- R6: Mode 1 (direct) targets `br_imm` unchanged, whatever the page registers hold.
- R7: Mode 2 (indirect) targets {jump page register, `br_ireg`}.
- R8: An accepted branch sets `br_valid` high in the next cycle, with `br_addr` equal to the target. In that same cycle `pc` equals `br_addr`. After a cycle with no accepted branch, `br_valid` is low and `br_addr` is 0.
- R9: With no accepted branch, `pc_step` advances `pc` by one modulo 2^24, so 0xFFFFFF steps to 0x000000. An accepted branch in the same cycle takes priority over the step.
- R10: A branch request with mode 3 is not accepted. `br_valid` stays low and the request leaves `pc` unchanged, although `pc_step` still applies.
- R11: A page write with `pg_wr_sel` = 3 changes no page register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pg_wr_en | input | 1 | Page register write strobe |
| pg_wr_sel | input | 2 | Page register select: 0, 1 = generators, 2 = jump page |
| pg_wr_data | input | 8 | Page value to write |
| ext_page | output | 8 | Page used for external data (generator 1) |
| dreq | input | 1 | Data address request |
| dgen_sel | input | 1 | Data generator select |
| dindex | input | 16 | Index (low address bits) |
| daddr | output | 24 | Generated data address |
| dvalid | output | 1 | Data address valid |
| br_req | input | 1 | Branch target request |
| br_mode | input | 2 | 0 relative, 1 direct, 2 indirect, 3 reserved |
| br_offset | input | 16 | Signed relative offset |
| br_imm | input | 24 | Direct target |
| br_ireg | input | 16 | Data address register for an indirect target |
| pc_step | input | 1 | Advance program counter by one |
| br_addr | output | 24 | Generated branch target |
| br_valid | output | 1 | Branch target valid |
| pc | output | 24 | Program counter |

## Verification
The bench targets the edges of the 24-bit space. It branches relative across 0xFFFFFF into page 0 and back again, and steps from 0xFFFFFF to zero. A design that drops the carry, or that sign-extends the offset wrongly, lands on the wrong page. The bench writes a page register in the same cycle as a request that uses it, in both the data and the indirect path. A design that forwards the new value would report the new page one cycle too early. The bench also drives the reserved select and the reserved mode, and collides a step with a branch. A design that decodes these loosely would corrupt a page, move `pc`, or raise a valid flag.

// File: rtl/pag_pkg.sv
package pag_pkg;

   typedef enum logic [1:0] {
      BR_REL = 2'd0,
      BR_DIR = 2'd1,
      BR_IND = 2'd2,
      BR_RSV = 2'd3
   } br_mode_e;

endpackage

// File: rtl/pag_page_bank.sv
module pag_page_bank #(
   parameter int PAGE_W = 8,
   parameter int NREG   = 3,
   parameter int SEL_W  = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [SEL_W-1:0]         wr_sel,
   input  logic [PAGE_W-1:0]        wr_data,
   output logic [NREG*PAGE_W-1:0]   pages
);

   initial begin
      if ((1 << SEL_W) < NREG) $error("pag_page_bank: SEL_W too narrow for NREG");
   end

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [PAGE_W-1:0] page_q;
      logic              hit;
      assign hit = wr_en && (wr_sel == SEL_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n)   page_q <= '0;
         else if (hit) page_q <= wr_data;
      end
      assign pages[g*PAGE_W +: PAGE_W] = page_q;
   end

endmodule

// File: rtl/pag_data_unit.sv
module pag_data_unit #(
   parameter int PAGE_W = 8,
   parameter int IDX_W  = 16,
   parameter int NDAG   = 2,
   parameter int NREG   = 3,
   parameter int DSEL_W = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NREG*PAGE_W-1:0]      pages,
   input  logic                        req,
   input  logic [DSEL_W-1:0]           gen_sel,
   input  logic [IDX_W-1:0]            index,
   output logic [PAGE_W+IDX_W-1:0]     addr,
   output logic                        valid
);

   localparam int ADDR_W = PAGE_W + IDX_W;

   logic [PAGE_W-1:0] page_mux;
   logic [ADDR_W-1:0] addr_q;
   logic              valid_q;

   always_comb begin
      page_mux = '0;
      for (int i = 0; i < NDAG; i++) begin
         if (gen_sel == DSEL_W'(i)) page_mux = pages[i*PAGE_W +: PAGE_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         addr_q  <= '0;
      end else begin
         valid_q <= req;
         addr_q  <= req ? {page_mux, index} : '0;
      end
   end

   assign addr  = addr_q;
   assign valid = valid_q;

endmodule

// File: rtl/pag_branch_unit.sv
module pag_branch_unit
   import pag_pkg::*;
#(
   parameter int PAGE_W = 8,
   parameter int IDX_W  = 16,
   parameter int OFS_W  = 16
) (
   input  logic [PAGE_W+IDX_W-1:0]  pc,
   input  logic [PAGE_W-1:0]        jump_page,
   input  logic                     req,
   input  logic [1:0]               mode,
   input  logic [OFS_W-1:0]         offset,
   input  logic [PAGE_W+IDX_W-1:0]  imm,
   input  logic [IDX_W-1:0]         ireg,
   output logic                     take,
   output logic [PAGE_W+IDX_W-1:0]  target
);

   localparam int ADDR_W = PAGE_W + IDX_W;

   logic [ADDR_W-1:0] ofs_ext;
   br_mode_e          mode_e;

   generate
      if (OFS_W == ADDR_W) begin : g_ofs_full
         assign ofs_ext = offset;
      end else begin : g_ofs_sext
         assign ofs_ext = {{(ADDR_W-OFS_W){offset[OFS_W-1]}}, offset};
      end
   endgenerate

   assign mode_e = br_mode_e'(mode);

   always_comb begin
      take   = req;
      target = '0;
      unique case (mode_e)
         BR_REL: target = pc + ofs_ext;
         BR_DIR: target = imm;
         BR_IND: target = {jump_page, ireg};
         BR_RSV: take   = 1'b0;
         default: take  = 1'b0;
      endcase
   end

endmodule

// File: rtl/pag_pc_unit.sv
module pag_pc_unit #(
   parameter int                  ADDR_W  = 24,
   parameter logic [ADDR_W-1:0]   BOOT_PC = 24'hFF0000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take,
   input  logic [ADDR_W-1:0]   target,
   input  logic                step,
   output logic [ADDR_W-1:0]   pc,
   output logic [ADDR_W-1:0]   br_addr,
   output logic                br_valid
);

   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] baddr_q;
   logic              bval_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q    <= BOOT_PC;
         baddr_q <= '0;
         bval_q  <= 1'b0;
      end else begin
         bval_q  <= take;
         baddr_q <= take ? target : '0;
         if (take)      pc_q <= target;
         else if (step) pc_q <= pc_q + {{(ADDR_W-1){1'b0}}, 1'b1};
      end
   end

   assign pc       = pc_q;
   assign br_addr  = baddr_q;
   assign br_valid = bval_q;

endmodule

// File: rtl/paged_addr_gen.sv
module paged_addr_gen #(
   parameter int PAGE_W  = 8,
   parameter int IDX_W   = 16,
   parameter int OFS_W   = 16,
   parameter int NDAG    = 2,
   parameter int EXT_DAG = 1,
   parameter int ADDR_W  = PAGE_W + IDX_W,
   parameter logic [ADDR_W-1:0] BOOT_PC = 24'hFF0000,
   parameter int NREG    = NDAG + 1,
   parameter int SEL_W   = $clog2(NREG),
   parameter int DSEL_W  = $clog2(NDAG)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pg_wr_en,
   input  logic [SEL_W-1:0]    pg_wr_sel,
   input  logic [PAGE_W-1:0]   pg_wr_data,
   output logic [PAGE_W-1:0]   ext_page,
   input  logic                dreq,
   input  logic [DSEL_W-1:0]   dgen_sel,
   input  logic [IDX_W-1:0]    dindex,
   output logic [ADDR_W-1:0]   daddr,
   output logic                dvalid,
   input  logic                br_req,
   input  logic [1:0]          br_mode,
   input  logic [OFS_W-1:0]    br_offset,
   input  logic [ADDR_W-1:0]   br_imm,
   input  logic [IDX_W-1:0]    br_ireg,
   input  logic                pc_step,
   output logic [ADDR_W-1:0]   br_addr,
   output logic                br_valid,
   output logic [ADDR_W-1:0]   pc
);

   localparam int JMP_IDX = NDAG;

   initial begin
      if (ADDR_W != PAGE_W + IDX_W) $error("paged_addr_gen: ADDR_W must equal PAGE_W+IDX_W");
      if (NDAG < 2)                 $error("paged_addr_gen: at least two data generators");
      if (EXT_DAG >= NDAG)          $error("paged_addr_gen: EXT_DAG out of range");
      if (OFS_W > ADDR_W || OFS_W < 2) $error("paged_addr_gen: OFS_W out of range");
   end

   logic [NREG*PAGE_W-1:0] pages;
   logic                   take;
   logic [ADDR_W-1:0]      target;

   pag_page_bank #(.PAGE_W(PAGE_W), .NREG(NREG), .SEL_W(SEL_W)) u_pages (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (pg_wr_en),
      .wr_sel  (pg_wr_sel),
      .wr_data (pg_wr_data),
      .pages   (pages)
   );

   pag_data_unit #(.PAGE_W(PAGE_W), .IDX_W(IDX_W), .NDAG(NDAG), .NREG(NREG),
                   .DSEL_W(DSEL_W)) u_data (
      .clk     (clk),
      .rst_n   (rst_n),
      .pages   (pages),
      .req     (dreq),
      .gen_sel (dgen_sel),
      .index   (dindex),
      .addr    (daddr),
      .valid   (dvalid)
   );

   pag_branch_unit #(.PAGE_W(PAGE_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_branch (
      .pc        (pc),
      .jump_page (pages[JMP_IDX*PAGE_W +: PAGE_W]),
      .req       (br_req),
      .mode      (br_mode),
      .offset    (br_offset),
      .imm       (br_imm),
      .ireg      (br_ireg),
      .take      (take),
      .target    (target)
   );

   pag_pc_unit #(.ADDR_W(ADDR_W), .BOOT_PC(BOOT_PC)) u_pc (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .target   (target),
      .step     (pc_step),
      .pc       (pc),
      .br_addr  (br_addr),
      .br_valid (br_valid)
   );

   assign ext_page = pages[EXT_DAG*PAGE_W +: PAGE_W];

endmodule

// File: rtl/pag_checker.sv
module pag_checker #(
   parameter int PAGE_W = 8,
   parameter int SEL_W  = 2,
   parameter int ADDR_W = 24,
   parameter int EXT_SEL = 1,
   parameter logic [ADDR_W-1:0] BOOT_PC = 24'hFF0000
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pg_wr_en,
   input logic [SEL_W-1:0]   pg_wr_sel,
   input logic [PAGE_W-1:0]  pg_wr_data,
   input logic [PAGE_W-1:0]  ext_page,
   input logic               dreq,
   input logic               dvalid,
   input logic [ADDR_W-1:0]  daddr,
   input logic               br_req,
   input logic [1:0]         br_mode,
   input logic               pc_step,
   input logic [ADDR_W-1:0]  br_addr,
   input logic               br_valid,
   input logic [ADDR_W-1:0]  pc
);

   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |=> (pc == BOOT_PC) && !dvalid && !br_valid && (ext_page == '0));

   assert_dvalid_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dreq |=> dvalid);

   assert_idle_data_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !dreq |=> !dvalid && (daddr == '0));

   assert_ext_page_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pg_wr_en && pg_wr_sel == SEL_W'(EXT_SEL)) |=> (ext_page == $past(pg_wr_data)));

   assert_pc_matches_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
      br_valid |-> (pc == br_addr));

   assert_step_wraps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!br_req && pc_step) |=> (pc == $past(pc) + {{(ADDR_W-1){1'b0}}, 1'b1}));

   assert_reserved_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (br_req && br_mode == 2'd3 && !pc_step) |=> !br_valid && $stable(pc));

   assert_bad_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pg_wr_en && pg_wr_sel == '1) |=> $stable(ext_page));

endmodule

bind paged_addr_gen pag_checker #(
   .PAGE_W (PAGE_W),
   .SEL_W  (SEL_W),
   .ADDR_W (ADDR_W),
   .EXT_SEL(EXT_DAG),
   .BOOT_PC(BOOT_PC)
) u_pag_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .pg_wr_en   (pg_wr_en),
   .pg_wr_sel  (pg_wr_sel),
   .pg_wr_data (pg_wr_data),
   .ext_page   (ext_page),
   .dreq       (dreq),
   .dvalid     (dvalid),
   .daddr      (daddr),
   .br_req     (br_req),
   .br_mode    (br_mode),
   .pc_step    (pc_step),
   .br_addr    (br_addr),
   .br_valid   (br_valid),
   .pc         (pc)
);

// File: tb/tb_paged_addr_gen.sv
module tb_paged_addr_gen;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pg_wr_en = 1'b0;
   logic [1:0]  pg_wr_sel = '0;
   logic [7:0]  pg_wr_data = '0;
   logic [7:0]  ext_page;
   logic        dreq = 1'b0;
   logic        dgen_sel = 1'b0;
   logic [15:0] dindex = '0;
   logic [23:0] daddr;
   logic        dvalid;
   logic        br_req = 1'b0;
   logic [1:0]  br_mode = '0;
   logic [15:0] br_offset = '0;
   logic [23:0] br_imm = '0;
   logic [15:0] br_ireg = '0;
   logic        pc_step = 1'b0;
   logic [23:0] br_addr;
   logic        br_valid;
   logic [23:0] pc;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   // behavioural reference state
   logic [7:0]  m_page [3];
   logic [23:0] m_pc, m_daddr, m_baddr;
   logic        m_dval, m_bval;

   paged_addr_gen dut (
      .clk(clk), .rst_n(rst_n),
      .pg_wr_en(pg_wr_en), .pg_wr_sel(pg_wr_sel), .pg_wr_data(pg_wr_data),
      .ext_page(ext_page),
      .dreq(dreq), .dgen_sel(dgen_sel), .dindex(dindex),
      .daddr(daddr), .dvalid(dvalid),
      .br_req(br_req), .br_mode(br_mode), .br_offset(br_offset),
      .br_imm(br_imm), .br_ireg(br_ireg), .pc_step(pc_step),
      .br_addr(br_addr), .br_valid(br_valid), .pc(pc)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles >= WATCHDOG) begin
         fails = fails + 1;
         checks = checks + 1;
         $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic check(input string tag, input string what,
                        input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      check(tag, "dvalid",   {23'd0, dvalid},   {23'd0, m_dval});
      check(tag, "daddr",    daddr,             m_daddr);
      check(tag, "br_valid", {23'd0, br_valid}, {23'd0, m_bval});
      check(tag, "br_addr",  br_addr,           m_baddr);
      check(tag, "pc",       pc,                m_pc);
      check(tag, "ext_page", {16'd0, ext_page}, {16'd0, m_page[1]});
   endtask

   // one clock with the current inputs; the model advances from the same inputs
   task automatic cyc(input string tag);
      logic [23:0] tgt;
      logic        tk;
      tk  = 1'b0;
      tgt = '0;
      if (br_req) begin
         case (br_mode)
            2'd0: begin tk = 1'b1; tgt = m_pc + {{8{br_offset[15]}}, br_offset}; end
            2'd1: begin tk = 1'b1; tgt = br_imm; end
            2'd2: begin tk = 1'b1; tgt = {m_page[2], br_ireg}; end
            default: tk = 1'b0;
         endcase
      end
      m_dval  = dreq;
      m_daddr = dreq ? {m_page[dgen_sel], dindex} : 24'd0;
      m_bval  = tk;
      m_baddr = tk ? tgt : 24'd0;
      if (tk)           m_pc = tgt;
      else if (pc_step) m_pc = m_pc + 24'd1;
      if (pg_wr_en && pg_wr_sel != 2'd3) m_page[pg_wr_sel] = pg_wr_data;
      @(posedge clk);
      @(negedge clk);
      compare_all(tag);
   endtask

   task automatic idle();
      pg_wr_en = 1'b0; dreq = 1'b0; br_req = 1'b0; pc_step = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 3; i++) m_page[i] = '0;
      m_pc = 24'hFF0000; m_daddr = '0; m_baddr = '0; m_dval = 1'b0; m_bval = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare_all("R1");
      rst_n = 1'b1;

      // R1: pages start at zero, data address carries page 0
      dreq = 1'b1; dgen_sel = 1'b0; dindex = 16'h4321; cyc("R1");
      dgen_sel = 1'b1; cyc("R2");
      idle(); cyc("R2");

      // R3: write and request in the same cycle use the old page
      pg_wr_en = 1'b1; pg_wr_sel = 2'd0; pg_wr_data = 8'h12;
      dreq = 1'b1; dgen_sel = 1'b0; dindex = 16'h3456; cyc("R3");
      pg_wr_en = 1'b0; cyc("R3");

      // R4: generator 1 page drives the external page
      pg_wr_en = 1'b1; pg_wr_sel = 2'd1; pg_wr_data = 8'hA5; dgen_sel = 1'b1; cyc("R4");
      pg_wr_en = 1'b0; cyc("R4");

      // R11: reserved select leaves every page alone
      pg_wr_en = 1'b1; pg_wr_sel = 2'd3; pg_wr_data = 8'hFF; cyc("R11");
      pg_wr_en = 1'b0; dgen_sel = 1'b0; cyc("R11");
      dgen_sel = 1'b1; cyc("R11");
      idle();

      // R6: direct target ignores pages
      br_req = 1'b1; br_mode = 2'd1; br_imm = 24'hFFFFF0; cyc("R6");
      // R5: relative wraps past the top, then back below zero
      br_mode = 2'd0; br_offset = 16'h0020; cyc("R5");
      br_offset = 16'hFFE0; cyc("R5");
      br_offset = 16'h8000; cyc("R5");
      idle(); cyc("R8");

      // R9: step wraps, and branch wins over step
      br_req = 1'b1; br_mode = 2'd1; br_imm = 24'hFFFFFF; cyc("R8");
      br_req = 1'b0; pc_step = 1'b1; cyc("R9");
      cyc("R9");
      br_req = 1'b1; br_mode = 2'd1; br_imm = 24'h00ABCD; cyc("R9");
      idle();

      // R7: indirect with jump page; same-cycle write uses old jump page
      pg_wr_en = 1'b1; pg_wr_sel = 2'd2; pg_wr_data = 8'h7E;
      br_req = 1'b1; br_mode = 2'd2; br_ireg = 16'hBEEF; cyc("R7");
      pg_wr_en = 1'b0; cyc("R7");

      // R10: reserved mode, alone and with a step
      br_mode = 2'd3; cyc("R10");
      pc_step = 1'b1; cyc("R10");
      idle(); cyc("R10");

      // mixed traffic against the model
      for (int n = 0; n < 400; n++) begin
         pg_wr_en   = ($urandom % 4) == 0;
         pg_wr_sel  = 2'($urandom);
         pg_wr_data = 8'($urandom);
         dreq       = ($urandom % 2) == 0;
         dgen_sel   = 1'($urandom);
         dindex     = 16'($urandom);
         br_req     = ($urandom % 3) == 0;
         br_mode    = 2'($urandom);
         br_offset  = 16'($urandom);
         br_imm     = 24'($urandom);
         br_ireg    = 16'($urandom);
         pc_step    = ($urandom % 2) == 0;
         cyc("R2/R3/R5/R7/R8/R9 mixed");
      end
      idle(); cyc("R8");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule